// File: doc/BRIEF.md
# Eight-bit addressable latch with demultiplexer mode

The block holds eight single-bit values and presents all of them in parallel on `q_o` at all times. A 3-bit address picks one bit, and a serial data input is written into that bit. Two active-high controls, a write inhibit and a master clear, are decoded together into four modes: addressed write, hold, clear all, and one-of-eight demultiplexer. In demultiplexer mode the addressed output carries the data input and the other seven outputs are forced low.

This implementation samples the inputs on the rising edge of `clk_i`, so each bit is a flip-flop rather than a transparent latch. A change at the inputs shows on `q_o` one clock edge later. An active-low asynchronous reset `rst_ni` clears the whole register without a clock edge.

Top module: `addr_latch`

## Requirements
- R1: With `wr_inhibit_i`=0 and `master_clr_i`=0, the bit selected by `addr_i` takes the value of `data_i` at the next rising edge of `clk_i`.
- R2: In that same write mode, the seven bits that are not addressed keep their values. When the address moves to a new bit, the previously addressed bit keeps the last value written to it.
- R3: With `wr_inhibit_i`=1 and `master_clr_i`=0, no bit of `q_o` changes, whatever `addr_i` and `data_i` are.
- R4: With `wr_inhibit_i`=1 and `master_clr_i`=1, every bit of `q_o` is 0 after the next rising edge.
- R5: With `wr_inhibit_i`=0 and `master_clr_i`=1, after the next rising edge the addressed bit equals `data_i` and every other bit is 0.
- R6: The address value k (0..7, with `addr_i[2]` as the most significant bit) selects `q_o[k]`.
- R7: While `rst_ni` is 0, `q_o` is all zeros. The clear takes effect at once, without waiting for a clock edge.
- R8: When `master_clr_i` falls and the block leaves demultiplexer mode, the bits keep the pattern the demultiplexer left. After that they follow the rules of the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, clears all bits |
| addr_i | input | 3 | Bit select |
| data_i | input | 1 | Serial data input |
| wr_inhibit_i | input | 1 | High blocks addressed writes |
| master_clr_i | input | 1 | High selects clear (with inhibit) or demultiplexer (without inhibit) |
| q_o | output | 8 | Parallel stored bits |

## Verification
The assertions assume that `addr_i`, `data_i`, `wr_inhibit_i` and `master_clr_i` are stable and known at each rising edge. Each mode property compares `q_o` one edge later against the mode, address and data sampled at the previous edge. The bench therefore changes these inputs only on the falling edge and reads `q_o` shortly after the rising edge. It drives `rst_ni` low only between edges, so that no mode property spans the asynchronous clear.

// File: rtl/al_pkg.sv
package al_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } al_mode_e;
endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
  import al_pkg::*;
(
  input  logic     wr_inhibit_i,
  input  logic     master_clr_i,
  output al_mode_e mode_o
);
  always_comb begin
    unique case ({master_clr_i, wr_inhibit_i})
      2'b00:   mode_o = MODE_WRITE;
      2'b01:   mode_o = MODE_HOLD;
      2'b10:   mode_o = MODE_DEMUX;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/al_addr_dec.sv
module al_addr_dec #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned N_BITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_BITS-1:0] sel_o
);
  for (genvar k = 0; k < N_BITS; k++) begin : g_sel
    assign sel_o[k] = (addr_i == ADDR_W'(k));
  end
endmodule

// File: rtl/al_bit_cell.sv
module al_bit_cell
  import al_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  al_mode_e mode_i,
  input  logic     sel_i,
  input  logic     data_i,
  output logic     q_o
);
  logic q_d;

  always_comb begin
    unique case (mode_i)
      MODE_WRITE: q_d = sel_i ? data_i : q_o;
      MODE_HOLD:  q_d = q_o;
      MODE_DEMUX: q_d = sel_i & data_i;
      default:    q_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import al_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned N_BITS = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_i,
  input  logic              wr_inhibit_i,
  input  logic              master_clr_i,
  output logic [N_BITS-1:0] q_o
);
  al_mode_e          mode;
  logic [N_BITS-1:0] sel;

  al_mode_dec u_mode (
    .wr_inhibit_i(wr_inhibit_i),
    .master_clr_i(master_clr_i),
    .mode_o      (mode)
  );

  al_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  for (genvar k = 0; k < N_BITS; k++) begin : g_bit
    al_bit_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .mode_i(mode),
      .sel_i (sel[k]),
      .data_i(data_i),
      .q_o   (q_o[k])
    );
  end
endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned N_BITS = 1 << ADDR_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              data_i,
  input logic              wr_inhibit_i,
  input logic              master_clr_i,
  input logic [N_BITS-1:0] q_o
);
  logic [N_BITS-1:0] mask;
  assign mask = N_BITS'(1) << addr_i;

  AST_WRITE_TAKES_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_inhibit_i && !master_clr_i) |=> (q_o[$past(addr_i)] == $past(data_i))); // R1

  AST_WRITE_OTHERS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_inhibit_i && !master_clr_i) |=> ((q_o & ~$past(mask)) == ($past(q_o) & ~$past(mask)))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_inhibit_i && !master_clr_i) |=> $stable(q_o)); // R3

  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_inhibit_i && master_clr_i) |=> (q_o == '0)); // R4

  AST_DEMUX_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_inhibit_i && master_clr_i) |=> (q_o == ($past(mask) & {N_BITS{$past(data_i)}}))); // R5

  AST_DEMUX_AT_MOST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_inhibit_i && master_clr_i) |=> $onehot0(q_o)); // R5
endmodule

bind addr_latch addr_latch_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/addr_latch_test.sv
module addr_latch_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 14;
  // {inhibit, clear, addr[2:0], data, expected q[7:0]}
  localparam logic [13:0] VEC [N_VEC] = '{
    {1'b0, 1'b0, 3'd0, 1'b1, 8'h01},
    {1'b0, 1'b0, 3'd7, 1'b1, 8'h81},
    {1'b0, 1'b0, 3'd3, 1'b1, 8'h89},
    {1'b0, 1'b0, 3'd0, 1'b0, 8'h88},
    {1'b1, 1'b0, 3'd5, 1'b1, 8'h88},
    {1'b1, 1'b0, 3'd3, 1'b0, 8'h88},
    {1'b0, 1'b1, 3'd5, 1'b1, 8'h20},
    {1'b0, 1'b1, 3'd2, 1'b0, 8'h00},
    {1'b0, 1'b1, 3'd6, 1'b1, 8'h40},
    {1'b0, 1'b0, 3'd1, 1'b1, 8'h42},
    {1'b0, 1'b0, 3'd4, 1'b1, 8'h52},
    {1'b1, 1'b1, 3'd4, 1'b1, 8'h00},
    {1'b0, 1'b0, 3'd2, 1'b1, 8'h04},
    {1'b1, 1'b0, 3'd2, 1'b0, 8'h04}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       data = 1'b0;
  logic       inh = 1'b1;
  logic       clr = 1'b0;
  logic [7:0] q;
  logic [7:0] model;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_latch uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data),
    .wr_inhibit_i(inh), .master_clr_i(clr), .q_o(q)
  );

  task automatic check(input logic [7:0] exp, input string req);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%h expected %h", req, q, exp);
    end
  endtask

  task automatic step(input logic i, input logic c, input logic [2:0] a, input logic d);
    @(negedge clk);
    inh = i; clr = c; addr = a; data = d;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] ref_next(input logic [7:0] cur, input logic i,
                                          input logic c, input logic [2:0] a, input logic d);
    logic [7:0] r;
    r = cur;
    case ({c, i})
      2'b00: r[a] = d;
      2'b01: r = cur;
      2'b10: begin r = '0; r[a] = d; end
      default: r = '0;
    endcase
    return r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 check(8'h00, "R7 reset state");
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < N_VEC; v++) begin
      logic [13:0] e;
      string tag;
      e = VEC[v];
      step(e[13], e[12], e[11:9], e[8]);
      case ({e[12], e[13]})
        2'b00: tag = (v > 0 && VEC[v-1][12]) ? "R8 leave demux" : "R1/R2/R6 write";
        2'b01: tag = "R3 hold";
        2'b10: tag = "R5 demux";
        default: tag = "R4 clear";
      endcase
      check(e[7:0], tag);
    end

    // exhaustive walk against a bench model
    model = q;
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 8; a++) begin
        for (int d = 0; d < 2; d++) begin
          logic [2:0] aa;
          logic       ii;
          logic       cc;
          logic       dd;
          aa = 3'(a); ii = m[0]; cc = m[1]; dd = (d == 1) ^ a[0];
          step(ii, cc, aa, dd);
          model = ref_next(model, ii, cc, aa, dd);
          case (m)
            0: check(model, "R1 R6 write walk");
            1: check(model, "R3 hold walk");
            2: check(model, "R5 demux walk");
            default: check(model, "R4 clear walk");
          endcase
        end
      end
      if (m == 0) begin
        for (int a = 0; a < 8; a++) begin
          step(1'b0, 1'b0, 3'(a), 1'b1);
          model = ref_next(model, 1'b0, 1'b0, 3'(a), 1'b1);
        end
        check(8'hFF, "R6 all bits set");
        model = q;
      end
    end

    // address moves during write: old bit keeps its last value
    step(1'b1, 1'b1, 3'd0, 1'b0);
    step(1'b0, 1'b0, 3'd6, 1'b1);
    step(1'b0, 1'b0, 3'd1, 1'b1);
    check(8'h42, "R2 address move keeps old bit");
    step(1'b0, 1'b0, 3'd1, 1'b0);
    check(8'h40, "R2 rewrite only new bit");

    // demux then leave by dropping clear while holding
    step(1'b0, 1'b1, 3'd3, 1'b1);
    check(8'h08, "R5 demux pattern");
    step(1'b1, 1'b0, 3'd7, 1'b1);
    check(8'h08, "R8 demux pattern kept");

    // asynchronous reset between edges
    step(1'b0, 1'b0, 3'd7, 1'b1);
    check(8'h88, "R1 write before reset");
    @(negedge clk);
    inh = 1'b1; clr = 1'b0;
    rst_n = 1'b0;
    #1 check(8'h00, "R7 async clear");
    @(negedge clk) rst_n = 1'b1;
    step(1'b1, 1'b0, 3'd0, 1'b1);
    check(8'h00, "R7 stays clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule